// File: doc/BRIEF.md
# Stack Transfer Sequencer for an 8-bit Core

This block carries out every control transfer of a small 8-bit core that goes through the stack or a vector. It covers power-up reset, level-triggered maskable interrupts, edge-triggered non-maskable interrupts, the software break, subroutine call and return, return from interrupt and the indirect jump. It owns the 16-bit program counter, the 8-bit stack pointer and the status byte. It talks to a synchronous byte-wide memory: read data appears one cycle after its address.

The decode stage hands the block one command at a time. It pulses `cmd_valid` while `done` is idle and then waits for the one-cycle `done` strobe. `done` rises in the cycle in which `pc` first shows the new value. Plain jumps and status changes also pass through this block, so it stays the only owner of these registers. Four behaviours of the older NMOS parts are kept on purpose:
- A call stacks the address of its own last byte.
- A break that meets a hardware interrupt is lost.
- Decimal mode survives interrupt entry.
- The indirect-jump pointer wraps inside its page.

Top module: `stk_xfer`

## Requirements
- R1: While `rst_n` is low and during the reset fetch, no memory write occurs. After release, `pc` takes the little-endian word at 0xFFFC (low) and 0xFFFD (high), and `done` pulses on the 3rd rising edge after release. At that point `sp` = 0xFD and `status` = 0x24.
- R2: Stack bytes live at 0x0100 + `sp`. A push writes at `sp` and then decrements it. A pull increments `sp` and then reads. `sp` wraps modulo 256, and every write goes to page 0x01.
- R3: Command encodings on `cmd_op`: 0 = jump, 1 = call, 2 = return, 3 = return from interrupt, 4 = break, 5 = indirect jump, 6 = load status, 7 = no effect. A call (1) pushes `pc`+2, high byte first, then sets `pc` to `cmd_arg`. `done` comes on the 3rd edge, counting the accepting edge as the 1st.
- R4: A return (2) pulls the low byte and then the high byte, and sets `pc` to that word plus one. `done` comes on the 4th edge.
- R5: The status byte has D at bit 3, I at bit 2, B at bit 4, and bit 5 always reads 1. When I is 0 and no command is presented, a high `irq` is taken. The entry pushes `pc` high, then `pc` low, then status with B = 0. It then sets I and loads `pc` from 0xFFFE/0xFFFF. `done` comes on the 7th edge. While I is 1, `irq` has no effect.
- R6: A rising edge on `nmi` is taken regardless of I, even from a one-cycle pulse. It uses the vector at 0xFFFA/0xFFFB and wins over a simultaneous `irq`.
- R7: A break (4) pushes `pc`+2 and then status with B = 1. It sets I and vectors through 0xFFFE/0xFFFF, with `done` on the 7th edge.
- R8: If a hardware interrupt is due in the cycle a break is presented, only the interrupt entry runs. It pushes `pc` itself with B = 0, and the break produces no further effect or `done`.
- R9: Interrupt and break entry leave the D flag unchanged.
- R10: Return from interrupt (3) pulls status (B forced to 0, bit 5 to 1), then the `pc` low byte, then the `pc` high byte. The pulled address is not adjusted, and `done` comes on the 5th edge.
- R11: Indirect jump (5) reads the target low byte at `cmd_arg` and the high byte at `{cmd_arg[15:8], cmd_arg[7:0]+1}`, so pointer 0xXXFF takes the high byte from 0xXX00. `done` comes on the 4th edge.
- R12: Jump (0) sets `pc` to `cmd_arg`. Load status (6) sets `status` to `cmd_arg` with bit 4 cleared and bit 5 set. Both, and code 7, give `done` on the 1st edge, and no memory write occurs while `done` is high.
- R13: A non-break command presented while an interrupt is due runs first. The interrupt then enters at the next idle cycle and stacks the new `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present (only while idle) |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 16 | Target, pointer or status value |
| irq | input | 1 | Maskable interrupt request, level |
| nmi | input | 1 | Non-maskable request, rising edge |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte |
| done | output | 1 | One-cycle strobe: transfer complete |

## Verification
The bench nests 127 calls so the stack pointer wraps through 0x00 to 0xFF. A design that left page one or got pull order wrong would return to the wrong addresses on the way back out. It sweeps all 256 low bytes of an indirect pointer. A design that carried into the next page would fetch the wrong high byte at 0xFF.

It makes a break collide with both interrupt kinds and checks the pushed address and B bit. A design that ran both would stack `pc`+2 or raise a second `done`. The bench also checks that D survives entry, that a masked `irq` does nothing, and that a call outranks a due interrupt. A wrong design would clear D, vector while masked, or stack the pre-call `pc`.

// File: rtl/stk_xfer.sv
module stk_xfer #(
  parameter logic [7:0]  SP_INIT = 8'hFD,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] cmd_arg,
  input  logic        irq,
  input  logic        nmi,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic        done
);
  localparam logic [2:0] OP_JMP = 3'd0, OP_CALL = 3'd1, OP_RET = 3'd2, OP_RTI = 3'd3,
                         OP_BRK = 3'd4, OP_JIND = 3'd5, OP_SETP = 3'd6;
  localparam logic [7:0] STK_PAGE = 8'h01;

  typedef enum logic [2:0] {S_RST, S_IDLE, S_INT, S_CALL, S_RET, S_RTI, S_JIND} st_t;

  st_t         st;
  logic [2:0]  step;
  logic [15:0] ret_a, ptr;
  logic [7:0]  lo;
  logic        brk_f, nmi_f, nmi_q, nmi_pend;

  wire         nmi_edge = nmi & ~nmi_q;
  wire         nmi_take = nmi_pend | nmi_edge;
  wire         irq_take = irq & ~status[2];
  wire         hw_take  = nmi_take | irq_take;
  wire         cmd_go   = cmd_valid & (cmd_op != OP_BRK);
  wire         idle     = (st == S_IDLE);
  wire         int_go   = idle & ~cmd_go & hw_take;
  wire         brk_go   = idle & ~cmd_go & ~hw_take & cmd_valid;
  wire [15:0]  vec      = nmi_f ? VEC_NMI : VEC_IRQ;
  wire [7:0]   sp_up    = sp + 8'd1;
  wire [7:0]   p_load   = {cmd_arg[7:6], 2'b10, cmd_arg[3:0]};
  wire [7:0]   p_pull   = {mem_rdata[7:6], 2'b10, mem_rdata[3:0]};

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    mem_addr  = {STK_PAGE, sp_up};
    case (st)
      S_RST:  mem_addr = (step == 3'd0) ? VEC_RST : VEC_RST + 16'd1;
      S_INT: begin
        case (step)
          3'd0: begin mem_we = 1'b1; mem_addr = {STK_PAGE, sp}; mem_wdata = ret_a[15:8]; end
          3'd1: begin mem_we = 1'b1; mem_addr = {STK_PAGE, sp}; mem_wdata = ret_a[7:0]; end
          3'd2: begin
            mem_we    = 1'b1;
            mem_addr  = {STK_PAGE, sp};
            mem_wdata = {status[7:6], 1'b1, brk_f, status[3:0]};
          end
          3'd3:    mem_addr = vec;
          default: mem_addr = vec + 16'd1;
        endcase
      end
      S_CALL: begin
        mem_we    = 1'b1;
        mem_addr  = {STK_PAGE, sp};
        mem_wdata = (step == 3'd0) ? ret_a[15:8] : ret_a[7:0];
      end
      S_JIND: mem_addr = (step == 3'd0) ? ptr : {ptr[15:8], ptr[7:0] + 8'd1};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RST;
      step     <= 3'd0;
      sp       <= SP_INIT;
      status   <= 8'h24;
      pc       <= 16'h0000;
      ret_a    <= 16'h0000;
      ptr      <= 16'h0000;
      lo       <= 8'h00;
      brk_f    <= 1'b0;
      nmi_f    <= 1'b0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      done     <= 1'b0;
    end else begin
      done  <= 1'b0;
      nmi_q <= nmi;
      step  <= step + 3'd1;
      if (int_go)        nmi_pend <= 1'b0;
      else if (nmi_edge) nmi_pend <= 1'b1;
      case (st)
        S_RST: begin
          if (step == 3'd1) lo <= mem_rdata;
          if (step == 3'd2) begin
            pc   <= {mem_rdata, lo};
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_IDLE: begin
          step <= 3'd0;
          if (cmd_go) begin
            case (cmd_op)
              OP_JMP:  begin pc <= cmd_arg; done <= 1'b1; end
              OP_SETP: begin status <= p_load; done <= 1'b1; end
              OP_CALL: begin ret_a <= pc + 16'd2; ptr <= cmd_arg; st <= S_CALL; end
              OP_RET:  st <= S_RET;
              OP_RTI:  st <= S_RTI;
              OP_JIND: begin ptr <= cmd_arg; st <= S_JIND; end
              default: done <= 1'b1;
            endcase
          end else if (int_go) begin
            ret_a <= pc;
            brk_f <= 1'b0;
            nmi_f <= nmi_take;
            st    <= S_INT;
          end else if (brk_go) begin
            ret_a <= pc + 16'd2;
            brk_f <= 1'b1;
            nmi_f <= 1'b0;
            st    <= S_INT;
          end
        end
        S_INT: begin
          if (step <= 3'd2) sp <= sp - 8'd1;
          if (step == 3'd2) status[2] <= 1'b1;
          if (step == 3'd4) lo <= mem_rdata;
          if (step == 3'd5) begin
            pc   <= {mem_rdata, lo};
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_CALL: begin
          sp <= sp - 8'd1;
          if (step == 3'd1) begin
            pc   <= ptr;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_RET: begin
          if (step <= 3'd1) sp <= sp_up;
          if (step == 3'd1) lo <= mem_rdata;
          if (step == 3'd2) begin
            pc   <= {mem_rdata, lo} + 16'd1;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_RTI: begin
          if (step <= 3'd2) sp <= sp_up;
          if (step == 3'd1) status <= p_pull;
          if (step == 3'd2) lo <= mem_rdata;
          if (step == 3'd3) begin
            pc   <= {mem_rdata, lo};
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_JIND: begin
          if (step == 3'd1) lo <= mem_rdata;
          if (step == 3'd2) begin
            pc   <= {mem_rdata, lo};
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp,
  input logic [7:0]  status,
  input logic        done
);
  a_r2_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01);

  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 8'd1);

  a_r9_decimal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> status[3] == $past(status[3]));

  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);
endmodule

bind stk_xfer stk_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .sp(sp), .status(status), .done(done)
);

// File: tb/sim_stk_xfer.sv
`timescale 1ns/1ps
module sim_stk_xfer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_arg = 16'h0;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;
  logic        mem_we, done;

  int nchk = 0, nbad = 0, nwr = 0;
  logic [7:0] mem [0:1023];

  stk_xfer u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .irq(irq), .nmi(nmi), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .status(status), .done(done));

  always #10 clk = ~clk;

  function automatic logic [9:0] ix(input logic [15:0] a);
    return {a[15], a[8:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin mem[ix(mem_addr)] <= mem_wdata; nwr++; end
    mem_rdata <= mem[ix(mem_addr)];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      cmd_valid = 1'b0;
      nmi = 1'b0;
    end while (!done && n < 40);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] arg, output int n);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    wait_done(n);
  endtask

  function automatic logic [7:0] stk(input logic [7:0] s);
    return mem[ix({8'h01, s})];
  endfunction

  function automatic logic [7:0] f0(input logic [7:0] x);
    return x * 8'd7 + 8'd3;
  endfunction

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] esp;
    logic [15:0] pcs [0:127];
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[ix(16'hFFFA)] = 8'h00; mem[ix(16'hFFFB)] = 8'hC0;
    mem[ix(16'hFFFC)] = 8'h34; mem[ix(16'hFFFD)] = 8'h12;
    mem[ix(16'hFFFE)] = 8'h00; mem[ix(16'hFFFF)] = 8'hE0;
    for (int i = 0; i < 256; i++) mem[ix(16'(i))] = f0(8'(i));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_done(n);
    check("R1 reset edges", n, 3);
    check("R1 reset pc", pc, 16'h1234);
    check("R1 reset sp", sp, 8'hFD);
    check("R1 reset status", status, 8'h24);
    check("R1 no write", nwr, 0);

    // R2 R3 R4: 127 nested calls wrap sp through 0x00
    esp = 8'hFD;
    for (int i = 0; i < 128; i++) pcs[i] = 16'h3000 + 16'(i) * 16'd97;
    issue(3'd0, pcs[0], n);
    check("R12 jump", pc, pcs[0]);
    check("R12 jump edges", n, 1);
    for (int i = 0; i < 127; i++) begin
      issue(3'd1, pcs[i+1], n);
      check("R3 call pc", pc, pcs[i+1]);
      check("R3 call edges", n, 3);
      check("R3 push hi", stk(esp), 8'((pcs[i] + 16'd2) >> 8));
      check("R3 push lo", stk(esp - 8'd1), 8'(pcs[i] + 16'd2));
      esp = esp - 8'd2;
      check("R2 sp after call", sp, esp);
    end
    check("R2 sp wrapped", sp, 8'hFF);
    for (int i = 126; i >= 0; i--) begin
      issue(3'd2, 16'h0, n);
      esp = esp + 8'd2;
      check("R4 ret pc", pc, pcs[i] + 16'd3);
      check("R4 ret edges", n, 4);
      check("R2 sp after ret", sp, esp);
    end

    // R11: all pointer low bytes in page zero
    for (int i = 0; i < 256; i++) begin
      issue(3'd5, 16'(i), n);
      check("R11 jind pc", pc, {f0(8'(i + 1)), f0(8'(i))});
      if (i == 0) check("R11 jind edges", n, 4);
    end

    // R5 R9 R10: irq with D set
    issue(3'd6, 16'h00F8, n);
    check("R12 setp", status, 8'hE8);
    issue(3'd6, 16'h0008, n);
    issue(3'd0, 16'h4567, n);
    esp = sp;
    irq = 1'b1;
    wait_done(n);
    irq = 1'b0;
    check("R5 irq edges", n, 7);
    check("R5 irq pc", pc, 16'hE000);
    check("R5 R9 irq status", status, 8'h2C);
    check("R5 push hi", stk(esp), 8'h45);
    check("R5 push lo", stk(esp - 8'd1), 8'h67);
    check("R5 push status B=0", stk(esp - 8'd2), 8'h28);
    check("R2 sp after irq", sp, esp - 8'd3);
    issue(3'd3, 16'h0, n);
    check("R10 rti edges", n, 5);
    check("R10 rti pc", pc, 16'h4567);
    check("R10 rti status", status, 8'h28);
    check("R10 rti sp", sp, esp);

    // R5: masked irq has no effect
    issue(3'd6, 16'h0004, n);
    irq = 1'b1;
    n = 0;
    repeat (10) begin @(negedge clk); if (done) n++; end
    irq = 1'b0;
    check("R5 masked no done", n, 0);
    check("R5 masked pc", pc, 16'h4567);
    check("R5 masked sp", sp, esp);

    // R6: nmi taken with I set
    issue(3'd0, 16'h7000, n);
    nmi = 1'b1;
    wait_done(n);
    check("R6 nmi edges", n, 7);
    check("R6 nmi pc", pc, 16'hC000);
    check("R6 nmi push status", stk(esp - 8'd2), 8'h24);
    issue(3'd3, 16'h0, n);
    check("R6 nmi return", pc, 16'h7000);

    // R7: break
    issue(3'd6, 16'h0000, n);
    issue(3'd0, 16'h5000, n);
    issue(3'd4, 16'h0, n);
    check("R7 brk edges", n, 7);
    check("R7 brk pc", pc, 16'hE000);
    check("R7 brk ret", {stk(esp), stk(esp - 8'd1)}, 16'h5002);
    check("R7 brk status B=1", stk(esp - 8'd2), 8'h30);
    check("R7 brk sets I", status, 8'h24);
    issue(3'd3, 16'h0, n);
    check("R10 rti clears B", status, 8'h20);
    check("R7 brk return", pc, 16'h5002);

    // R8: break colliding with irq
    issue(3'd0, 16'h6000, n);
    irq = 1'b1;
    issue(3'd4, 16'h0, n);
    irq = 1'b0;
    check("R8 irq+brk pc", pc, 16'hE000);
    check("R8 irq+brk ret", {stk(esp), stk(esp - 8'd1)}, 16'h6000);
    check("R8 irq+brk B=0", stk(esp - 8'd2), 8'h20);
    n = 0;
    repeat (8) begin @(negedge clk); if (done) n++; end
    check("R8 no second done", n, 0);
    check("R8 sp once", sp, esp - 8'd3);
    issue(3'd3, 16'h0, n);
    check("R8 return", pc, 16'h6000);

    // R8: break colliding with nmi while masked
    issue(3'd6, 16'h0004, n);
    issue(3'd0, 16'h7100, n);
    nmi = 1'b1;
    issue(3'd4, 16'h0, n);
    check("R8 nmi+brk pc", pc, 16'hC000);
    check("R8 nmi+brk ret", {stk(esp), stk(esp - 8'd1)}, 16'h7100);
    check("R8 nmi+brk B=0", stk(esp - 8'd2), 8'h24);
    issue(3'd3, 16'h0, n);

    // R6: nmi wins over irq
    issue(3'd6, 16'h0000, n);
    irq = 1'b1; nmi = 1'b1;
    wait_done(n);
    irq = 1'b0;
    check("R6 nmi priority", pc, 16'hC000);
    issue(3'd3, 16'h0, n);
    check("R6 priority return status", status, 8'h20);

    // R13: call outranks due irq
    issue(3'd0, 16'h8000, n);
    irq = 1'b1;
    issue(3'd1, 16'h9000, n);
    check("R13 call first", pc, 16'h9000);
    check("R13 call edges", n, 3);
    wait_done(n);
    irq = 1'b0;
    check("R13 irq after", pc, 16'hE000);
    check("R13 irq edges", n, 7);
    check("R13 stacked new pc", {stk(esp - 8'd2), stk(esp - 8'd3)}, 16'h9000);
    issue(3'd3, 16'h0, n);
    check("R13 rti", pc, 16'h9000);
    issue(3'd2, 16'h0, n);
    check("R13 ret", pc, 16'h8003);
    check("R13 sp home", sp, esp);

    // R12: code 7 has no effect
    issue(3'd7, 16'hABCD, n);
    check("R12 op7 edges", n, 1);
    check("R12 op7 pc", pc, 16'h8003);
    check("R12 op7 status", status, 8'h20);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule